// File: doc/BRIEF.md
# Two-Way Set-Associative Byte Cache with Selectable Victim Policy

This block sits between a processor and a byte-wide backing memory. The processor presents an address and a strobe. A request can be a read or a write. The cache looks up the address combinationally in the idle state and answers with a one-cycle response pulse. The response carries the byte, a hit flag and a two-bit label. The label says whether the access hit, missed into an empty way (cold), or had to displace a valid way (conflict). Each set has two ways, and each way holds a tag, one data byte, a valid bit and a dirty bit.

The static `policy_i` input chooses the victim when both ways of a set are valid. The choices are the less recently touched way, the more recently touched way, or a bit taken from a free-running shift register. The `WRITE_BACK` parameter selects how writes are handled. With the parameter set, writes stay in the cache and mark the way dirty, and dirty victims are flushed to memory before the way is reused. With it clear, every write goes straight to memory. Memory transfers use a request that is held until a one-cycle acknowledge arrives.

Top module: `assoc_cache2w`

## Requirements
- R1: After reset every way is invalid, `req_ready_o` is 1, and `resp_valid_o` and `mem_req_o` are 0. The first access to any set is therefore a cold miss.
- R2: Bit 0 of the address picks the set and bits 3:1 form the tag. A read hit returns the stored byte with `resp_hit_o`=1 and kind code 2'b00, one cycle after acceptance, with no memory traffic.
- R3: A miss is labelled 2'b01 (cold) when the selected set has an invalid way. It is labelled 2'b10 (conflict) when both ways are valid.
- R4: On a miss, way 0 is filled if it is invalid, then way 1 if it is invalid. A valid way is evicted only when both are valid, whatever the policy.
- R5: With `policy_i`=2'b00 the victim is the way not most recently touched. Reading 1001, 0001, 0101, 1101 after reset gives cold, cold, conflict, conflict, and leaves set 1 holding tags 010 and 110.
- R6: With `policy_i`=2'b01 the victim is the most recently touched way.
- R7: With `policy_i`=2'b10 or 2'b11 the victim is bit 0 of an 8-bit shift register. The register loads 0xA5 at reset and shifts left every clock, with feedback bit7^bit5^bit4^bit3 entering bit 0. The value in use is the one held in the cycle the request is accepted.
- R8: A read miss issues a one-byte memory read to the requested address. The fetched byte is installed clean and returned in the cycle after the acknowledge.
- R9: In write-back mode a write hit updates the byte, marks the way dirty and responds one cycle after acceptance with no memory traffic. A write miss allocates a way with the written byte and does not read memory.
- R10: In write-back mode, evicting a dirty way first writes its old byte to address {old tag, set}. Only after that acknowledge is the new byte read, or for a write, installed.
- R11: In write-through mode every write goes to memory and responds in the cycle after the acknowledge. A hit also updates the cached byte. A miss allocates nothing, so a later read of that address misses.
- R12: The per-set recency marker moves to the touched way on every hit and on every fill. It does not change on a write-through write miss.
- R13: `req_ready_o` is 0 while a memory transfer is in progress. `mem_req_o`, `mem_addr_o` and `mem_we_o` stay stable until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Victim policy: 00 LRU, 01 MRU, 1x random |
| req_valid_i | input | 1 | Request strobe, accepted when ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Write byte |
| req_ready_o | output | 1 | Cache idle and able to accept |
| resp_valid_o | output | 1 | One-cycle response pulse |
| resp_data_o | output | DATA_W | Read byte, or the written byte for writes |
| resp_hit_o | output | 1 | Access hit |
| resp_kind_o | output | 2 | 00 hit, 01 cold miss, 10 conflict miss |
| mem_req_o | output | 1 | Memory transfer request, held until acknowledge |
| mem_we_o | output | 1 | Memory transfer is a write |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Memory write byte |
| mem_ack_i | input | 1 | One-cycle transfer acknowledge |
| mem_rdata_i | input | DATA_W | Memory read byte, valid with acknowledge |

## Verification
The response latency depends on the access type, so the bench predicts the exact number of falling edges from acceptance to the response. Hits and write-back write misses answer after 1 cycle. Clean read misses and write-through writes answer after 2, because the bench memory acknowledges one cycle after it sees a request. A dirty eviction followed by a fill takes 4, and a dirty eviction followed by a write install takes 2. The bench counts edges while it waits and compares the count with its prediction. It then samples data, hit flag and kind at that same falling edge, and compares the whole backing memory with its reference image.

// File: rtl/assoc_cache2w_pkg.sv
package assoc_cache2w_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2,
        ST_THRU  = 2'd3
    } ctl_state_e;

    typedef enum logic [1:0] {
        KIND_HIT      = 2'd0,
        KIND_COLD     = 2'd1,
        KIND_CONFLICT = 2'd2
    } access_kind_e;

    localparam logic [1:0] POL_LRU = 2'd0;
    localparam logic [1:0] POL_MRU = 2'd1;

endpackage

// File: rtl/assoc_cache2w_lfsr.sv
module assoc_cache2w_lfsr #(
    parameter logic [7:0] SEED = 8'hA5
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic bit_o
);
    logic [7:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[6:0], sr_q[7] ^ sr_q[5] ^ sr_q[4] ^ sr_q[3]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= SEED;
        else         sr_q <= sr_d;
    end

    assign bit_o = sr_q[0];
endmodule

// File: rtl/assoc_cache2w_victim.sv
module assoc_cache2w_victim
    import assoc_cache2w_pkg::*;
(
    input  logic [1:0] valid_i,
    input  logic       recent_i,
    input  logic [1:0] policy_i,
    input  logic       rnd_i,
    output logic       way_o,
    output logic       cold_o
);
    always_comb begin
        cold_o = 1'b1;
        way_o  = 1'b0;
        if (!valid_i[0]) begin
            way_o = 1'b0;
        end else if (!valid_i[1]) begin
            way_o = 1'b1;
        end else begin
            cold_o = 1'b0;
            case (policy_i)
                POL_LRU: way_o = ~recent_i;
                POL_MRU: way_o = recent_i;
                default: way_o = rnd_i;
            endcase
        end
    end
endmodule

// File: rtl/assoc_cache2w.sv
module assoc_cache2w
    import assoc_cache2w_pkg::*;
#(
    parameter int         ADDR_W     = 4,
    parameter int         SET_W      = 1,
    parameter int         DATA_W     = 8,
    parameter int         WRITE_BACK = 1,
    parameter logic [7:0] RND_SEED   = 8'hA5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        policy_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_ready_o,
    output logic              resp_valid_o,
    output logic [DATA_W-1:0] resp_data_o,
    output logic              resp_hit_o,
    output logic [1:0]        resp_kind_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int NSETS = 1 << SET_W;

    typedef struct packed {
        ctl_state_e                          st;
        logic [NSETS-1:0][1:0]               vld;
        logic [NSETS-1:0][1:0]               dty;
        logic [NSETS-1:0][1:0][TAG_W-1:0]    tag;
        logic [NSETS-1:0][1:0][DATA_W-1:0]   dat;
        logic [NSETS-1:0]                    mru;
        logic [SET_W-1:0]                    set;
        logic [TAG_W-1:0]                    tg;
        logic                                way;
        logic                                wr;
        logic [DATA_W-1:0]                   wd;
        logic                                rv;
        logic                                rhit;
        access_kind_e                        rkind;
        logic [DATA_W-1:0]                   rdata;
    } ctl_t;

    ctl_t q, n;

    logic [SET_W-1:0]  a_set;
    logic [TAG_W-1:0]  a_tag;
    logic              hit0, hit1, v_way, v_cold, rnd;
    logic              inst;
    logic              inst_dirty;
    logic [DATA_W-1:0] inst_data;

    assign a_set = req_addr_i[SET_W-1:0];
    assign a_tag = req_addr_i[ADDR_W-1:SET_W];

    assoc_cache2w_lfsr #(.SEED(RND_SEED)) u_rnd (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .bit_o  (rnd)
    );

    assoc_cache2w_victim u_vic (
        .valid_i  (q.vld[a_set]),
        .recent_i (q.mru[a_set]),
        .policy_i (policy_i),
        .rnd_i    (rnd),
        .way_o    (v_way),
        .cold_o   (v_cold)
    );

    always_comb begin
        n          = q;
        n.rv       = 1'b0;
        inst       = 1'b0;
        inst_dirty = 1'b0;
        inst_data  = '0;
        hit0 = q.vld[a_set][0] && (q.tag[a_set][0] == a_tag);
        hit1 = q.vld[a_set][1] && (q.tag[a_set][1] == a_tag);
        case (q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    n.set = a_set;
                    n.tg  = a_tag;
                    n.wr  = req_write_i;
                    n.wd  = req_wdata_i;
                    if (hit0 || hit1) begin
                        n.rhit         = 1'b1;
                        n.rkind        = KIND_HIT;
                        n.way          = hit1;
                        n.mru[a_set]   = hit1;
                        if (!req_write_i) begin
                            n.rv    = 1'b1;
                            n.rdata = q.dat[a_set][hit1];
                        end else begin
                            n.rdata              = req_wdata_i;
                            n.dat[a_set][hit1]   = req_wdata_i;
                            if (WRITE_BACK != 0) begin
                                n.dty[a_set][hit1] = 1'b1;
                                n.rv               = 1'b1;
                            end else begin
                                n.st = ST_THRU;
                            end
                        end
                    end else begin
                        n.rhit  = 1'b0;
                        n.rkind = v_cold ? KIND_COLD : KIND_CONFLICT;
                        n.way   = v_way;
                        n.rdata = req_wdata_i;
                        if (req_write_i && (WRITE_BACK == 0)) begin
                            n.st = ST_THRU;
                        end else if (q.vld[a_set][v_way] && q.dty[a_set][v_way]) begin
                            n.st = ST_EVICT;
                        end else if (req_write_i) begin
                            inst       = 1'b1;
                            inst_dirty = 1'b1;
                            inst_data  = req_wdata_i;
                        end else begin
                            n.st = ST_FILL;
                        end
                    end
                end
            end
            ST_EVICT: begin
                if (mem_ack_i) begin
                    if (q.wr) begin
                        inst       = 1'b1;
                        inst_dirty = 1'b1;
                        inst_data  = q.wd;
                    end else begin
                        n.st = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ack_i) begin
                    inst      = 1'b1;
                    inst_data = mem_rdata_i;
                end
            end
            default: begin
                if (mem_ack_i) begin
                    n.rv = 1'b1;
                    n.st = ST_IDLE;
                end
            end
        endcase
        if (inst) begin
            n.vld[n.set][n.way] = 1'b1;
            n.tag[n.set][n.way] = n.tg;
            n.dat[n.set][n.way] = inst_data;
            n.dty[n.set][n.way] = inst_dirty;
            n.mru[n.set]        = n.way;
            n.rdata             = inst_data;
            n.rv                = 1'b1;
            n.st                = ST_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= n;
    end

    assign req_ready_o  = (q.st == ST_IDLE);
    assign resp_valid_o = q.rv;
    assign resp_data_o  = q.rdata;
    assign resp_hit_o   = q.rhit;
    assign resp_kind_o  = q.rkind;
    assign mem_req_o    = (q.st != ST_IDLE);
    assign mem_we_o     = (q.st == ST_EVICT) || (q.st == ST_THRU);
    assign mem_addr_o   = (q.st == ST_EVICT) ? {q.tag[q.set][q.way], q.set} : {q.tg, q.set};
    assign mem_wdata_o  = (q.st == ST_EVICT) ? q.dat[q.set][q.way] : q.wd;

endmodule

// File: rtl/assoc_cache2w_chk.sv
module assoc_cache2w_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_ready_o,
    input logic              resp_valid_o,
    input logic              resp_hit_o,
    input logic [1:0]        resp_kind_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_ack_i
);
    // R13: no new request accepted during a memory transfer
    a_r13_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |-> !req_ready_o);

    // R13: transfer fields hold until acknowledged
    a_r13_req_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R2: hits always carry the hit code
    a_r2_hit_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resp_valid_o && resp_hit_o) |-> (resp_kind_o == 2'b00));

    // R3: misses carry cold or conflict code
    a_r3_miss_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resp_valid_o && !resp_hit_o) |-> ((resp_kind_o == 2'b01) || (resp_kind_o == 2'b10)));

    // R8: an acknowledged read is answered in the next cycle
    a_r8_fill_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_we_o && mem_ack_i) |=> resp_valid_o);
endmodule

bind assoc_cache2w assoc_cache2w_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_ready_o  (req_ready_o),
    .resp_valid_o (resp_valid_o),
    .resp_hit_o   (resp_hit_o),
    .resp_kind_o  (resp_kind_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_ack_i    (mem_ack_i)
);

// File: tb/assoc_cache2w_tb.sv
module assoc_cache2w_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] policy = 2'b00;
    always #(CLK_PERIOD/2) clk = ~clk;

    // index 0: write-back instance, index 1: write-through instance
    logic       rq_v   [2];
    logic       rq_we  [2];
    logic [3:0] rq_a   [2];
    logic [7:0] rq_wd  [2];
    logic       rdy    [2];
    logic       rs_v   [2];
    logic [7:0] rs_d   [2];
    logic       rs_h   [2];
    logic [1:0] rs_k   [2];
    logic       m_req  [2];
    logic       m_we   [2];
    logic [3:0] m_addr [2];
    logic [7:0] m_wd   [2];
    logic       m_ack  [2];
    logic [7:0] m_rd   [2];

    logic [7:0] bmem [2][16];
    logic [7:0] emem [2][16];

    bit         md_vld [2][2][2];
    bit         md_dty [2][2][2];
    logic [2:0] md_tag [2][2][2];
    logic [7:0] md_dat [2][2][2];
    bit         md_mru [2][2];
    logic [7:0] lf;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic       last_hit;
    logic [1:0] last_kind;

    assoc_cache2w #(.WRITE_BACK(1)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .policy_i(policy),
        .req_valid_i(rq_v[0]), .req_write_i(rq_we[0]), .req_addr_i(rq_a[0]), .req_wdata_i(rq_wd[0]),
        .req_ready_o(rdy[0]), .resp_valid_o(rs_v[0]), .resp_data_o(rs_d[0]),
        .resp_hit_o(rs_h[0]), .resp_kind_o(rs_k[0]),
        .mem_req_o(m_req[0]), .mem_we_o(m_we[0]), .mem_addr_o(m_addr[0]), .mem_wdata_o(m_wd[0]),
        .mem_ack_i(m_ack[0]), .mem_rdata_i(m_rd[0]));

    assoc_cache2w #(.WRITE_BACK(0)) u_dut_wt (
        .clk_i(clk), .rst_ni(rst_n), .policy_i(policy),
        .req_valid_i(rq_v[1]), .req_write_i(rq_we[1]), .req_addr_i(rq_a[1]), .req_wdata_i(rq_wd[1]),
        .req_ready_o(rdy[1]), .resp_valid_o(rs_v[1]), .resp_data_o(rs_d[1]),
        .resp_hit_o(rs_h[1]), .resp_kind_o(rs_k[1]),
        .mem_req_o(m_req[1]), .mem_we_o(m_we[1]), .mem_addr_o(m_addr[1]), .mem_wdata_o(m_wd[1]),
        .mem_ack_i(m_ack[1]), .mem_rdata_i(m_rd[1]));

    // reference shift register, R7
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) lf <= 8'hA5;
        else        lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end

    // backing memory: acknowledge one cycle after a request is seen
    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n || m_ack[k]) begin
                m_ack[k] <= 1'b0;
            end else if (m_req[k]) begin
                m_ack[k] <= 1'b1;
                if (m_we[k]) bmem[k][m_addr[k]] <= m_wd[k];
                else         m_rd[k] <= bmem[k][m_addr[k]];
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run exceeded cycle budget (actual %0d, expected < 150000)", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int k = 0; k < 2; k++) begin
            rq_v[k] = 0; rq_we[k] = 0; rq_a[k] = 0; rq_wd[k] = 0;
            md_mru[k][0] = 0; md_mru[k][1] = 0;
            for (int s = 0; s < 2; s++)
                for (int w = 0; w < 2; w++) begin
                    md_vld[k][s][w] = 0; md_dty[k][s][w] = 0;
                    md_tag[k][s][w] = 0; md_dat[k][s][w] = 0;
                end
        end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(rdy[k] == 1'b1, "R1", "ready after reset", int'(rdy[k]), 1);
            chk(rs_v[k] == 1'b0, "R1", "resp_valid after reset", int'(rs_v[k]), 0);
            chk(m_req[k] == 1'b0, "R1", "mem_req after reset", int'(m_req[k]), 0);
        end
    endtask

    // one access, predicted from the requirements and checked at the ports
    task automatic access(input int k, input bit we, input logic [3:0] a, input logic [7:0] wd);
        bit s;
        logic [2:0] t;
        bit h0, h1, hit, hw, vw, cold;
        int exp_lat, lat;
        logic [7:0] exp_d;
        logic [1:0] exp_k;
        s = a[0]; t = a[3:1];
        h0 = md_vld[k][s][0] && md_tag[k][s][0] == t;
        h1 = md_vld[k][s][1] && md_tag[k][s][1] == t;
        hit = h0 || h1; hw = h1;
        if (hit) begin
            exp_k = 2'b00;
            md_mru[k][s] = hw;                  // R12
            if (!we) begin
                exp_d = md_dat[k][s][hw]; exp_lat = 1;   // R2
            end else begin
                exp_d = wd; md_dat[k][s][hw] = wd;
                if (k == 0) begin md_dty[k][s][hw] = 1; exp_lat = 1; end  // R9
                else begin emem[k][a] = wd; exp_lat = 2; end              // R11
            end
        end else begin
            // R4 invalid first, R5/R6/R7 policy choice
            if (!md_vld[k][s][0]) begin vw = 0; cold = 1; end
            else if (!md_vld[k][s][1]) begin vw = 1; cold = 1; end
            else begin
                cold = 0;
                if (policy == 2'b00)      vw = !md_mru[k][s];
                else if (policy == 2'b01) vw = md_mru[k][s];
                else                      vw = lf[0];
            end
            exp_k = cold ? 2'b01 : 2'b10;                 // R3
            if (we && k == 1) begin
                emem[k][a] = wd; exp_d = wd; exp_lat = 2; // R11 no allocate
            end else begin
                exp_lat = 0;
                if (md_vld[k][s][vw] && md_dty[k][s][vw]) begin
                    emem[k][{md_tag[k][s][vw], s}] = md_dat[k][s][vw];  // R10
                    exp_lat = 2;
                end
                if (we) begin
                    exp_d = wd; md_dty[k][s][vw] = 1;
                    exp_lat = (exp_lat == 0) ? 1 : 2;
                end else begin
                    exp_d = emem[k][a]; md_dty[k][s][vw] = 0;   // R8
                    exp_lat = exp_lat + 2;
                end
                md_vld[k][s][vw] = 1; md_tag[k][s][vw] = t; md_dat[k][s][vw] = exp_d;
                md_mru[k][s] = vw;
            end
        end
        rq_v[k] = 1; rq_we[k] = we; rq_a[k] = a; rq_wd[k] = wd;
        @(negedge clk);
        lat = 1;
        rq_v[k] = 0;
        if (exp_lat > 1) chk(rdy[k] == 1'b0, "R13", "ready during transfer", int'(rdy[k]), 0);
        while (!rs_v[k] && lat < 16) begin
            @(negedge clk);
            lat++;
        end
        last_hit = rs_h[k]; last_kind = rs_k[k];
        chk(lat == exp_lat, "R8", "response latency", lat, exp_lat);
        chk(rs_d[k] == exp_d, "R2", "response data", int'(rs_d[k]), int'(exp_d));
        chk(rs_h[k] == hit, "R2", "hit flag", int'(rs_h[k]), int'(hit));
        chk(rs_k[k] == exp_k, "R3", "kind code", int'(rs_k[k]), int'(exp_k));
        for (int i = 0; i < 16; i++)
            if (bmem[k][i] !== emem[k][i])
                chk(0, (k == 0) ? "R10" : "R11", "memory image", int'(bmem[k][i]), int'(emem[k][i]));
        checks++;
    endtask

    initial begin
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < 16; i++) begin
                bmem[k][i] = 8'(i * 29 + 7);
                emem[k][i] = 8'(i * 29 + 7);
            end
        for (int k = 0; k < 2; k++) begin
            m_ack[k] = 0; m_rd[k] = 0;
        end

        // R5: LRU sequence in set 1
        policy = 2'b00;
        do_reset();
        access(0, 0, 4'b1001, 0);
        chk(last_kind == 2'b01, "R5", "1st kind", int'(last_kind), 1);
        access(0, 0, 4'b0001, 0);
        chk(last_kind == 2'b01, "R5", "2nd kind", int'(last_kind), 1);
        access(0, 0, 4'b0101, 0);
        chk(last_kind == 2'b10, "R5", "3rd kind", int'(last_kind), 2);
        access(0, 0, 4'b1101, 0);
        chk(last_kind == 2'b10, "R5", "4th kind", int'(last_kind), 2);
        access(0, 0, 4'b0101, 0);
        chk(last_hit == 1'b1, "R5", "tag 010 kept", int'(last_hit), 1);
        access(0, 0, 4'b1101, 0);
        chk(last_hit == 1'b1, "R5", "tag 110 kept", int'(last_hit), 1);

        // R6: MRU evicts the latest fill
        policy = 2'b01;
        do_reset();
        access(0, 0, 4'b1001, 0);
        access(0, 0, 4'b0001, 0);
        access(0, 0, 4'b0101, 0);
        access(0, 0, 4'b1001, 0);
        chk(last_hit == 1'b1, "R6", "older line survives", int'(last_hit), 1);

        // R4: both ways fill before anything is evicted
        policy = 2'b10;
        do_reset();
        access(0, 0, 4'b0011, 0);
        access(0, 0, 4'b0001, 0);
        access(0, 0, 4'b0011, 0);
        chk(last_hit == 1'b1, "R4", "first fill retained", int'(last_hit), 1);

        // R9/R10: dirty lines flushed on eviction
        policy = 2'b00;
        do_reset();
        access(0, 1, 4'b0001, 8'h3C);
        access(0, 1, 4'b0011, 8'hC3);
        access(0, 0, 4'b0101, 0);
        chk(bmem[0][1] == 8'h3C, "R10", "dirty byte written back", int'(bmem[0][1]), 8'h3C);

        // R11: write-through miss allocates nothing
        access(1, 1, 4'b0110, 8'h5A);
        chk(bmem[1][6] == 8'h5A, "R11", "write reached memory", int'(bmem[1][6]), 8'h5A);
        access(1, 0, 4'b0110, 0);
        chk(last_hit == 1'b0, "R11", "no allocation", int'(last_hit), 0);

        // R7 and R12: sweeps under every policy on both instances
        for (int p = 0; p < 4; p++) begin
            policy = 2'(p);
            do_reset();
            for (int i = 0; i < 64; i++) begin
                access(i % 2, ((i * 3) % 5) == 1, 4'((i * 11 + (i >> 2)) & 15), 8'(i * 13 + 5));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule